// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between an 8-bit microcontroller bus and a small behavioural flash array. Byte writes from the bus are checked against unlock patterns and turned into commands. A valid command moves the block into one of several read modes: plain array reads, an identifier and protection query, or a status view while a simulated program or erase is running. Reads return data through a single multiplexed read port.

The array is split into `NSECT` sectors of `2**OFS_W` bytes each. A one-hot sector-select bus chooses the sector, and the low `OFS_W` address bits choose the byte. Programming can only clear bits. Erase sets a whole sector back to FFh. A parameter mask marks sectors as write-protected.

A program or erase runs on a cycle counter whose length is set by a parameter. While it runs, reads return a status byte instead of array data. A low-supply lockout input blocks every write.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read-array mode, every array byte reads FFh, and `rdata_o` is 00h.
- R2: A read happens on a rising edge of `re_i` while exactly one `sect_i` bit is high. The addressed value appears on `rdata_o` one clock later and is held until the next such read. A read with no sector selected leaves `rdata_o` unchanged. In read-array mode, and in the middle of an unlock sequence, the addressed value is the byte at (selected sector, `addr_i[OFS_W-1:0]`).
- R3: The unlock sequence is AAh written at 555h, then 55h written at AAAh, then a command byte written at 555h. Any other value or address at one of these steps returns the block to read-array mode.
- R4: Command 90h enters query mode. In query mode a read with `addr_i[1:0]`=0 returns E8h.
- R5: In query mode a read with `addr_i[1:0]`=2 returns 01h if the selected sector is protected (its bit set in `PROT_MASK`) and 00h if it is not. Other addresses return 00h.
- R6: Writing F0h returns the block to read-array mode. This works as a single write in query mode or in the fault state, and also as the command byte of an unlock sequence.
- R7: Command A0h followed by one data write at a sector/offset starts a program. The stored byte becomes old AND data after `PGM_CYC` clocks in busy state.
- R8: While an operation is busy or faulted, reads return a status byte. Bit 7 is the complement of bit 7 of the data being programmed (0 for erase). Bit 6 is the toggle flag. Bit 5 is the error flag. Bit 3 is the erase flag. All other bits are 0.
- R9: Bit 6 of the status byte is 0 on the first status read after an operation starts, and flips on every status read after that. Status reads do not change the array or the operation. Once the operation completes, reads return array data.
- R10: The sequence AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, 30h@any address erases the selected sector to all FFh after `ERS_CYC` clocks. Bit 3 of the status byte is 1 during the erase.
- R11: Programming or erasing a protected sector, or programming data with a 1 where the stored byte has a 0, enters the fault state. In the fault state bit 5 of the status byte is 1, the array is left unchanged, and the block stays faulted until F0h is written.
- R12: A write strobe edge while `lockout_i` is high has no effect.
- R13: A `we_i` that is already high when reset is released causes no write until it falls and rises again. Writes while an operation is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, acts on its rising edge |
| re_i | input | 1 | Read strobe, acts on its rising edge |
| sect_i | input | NSECT | One-hot sector select, active high |
| lockout_i | input | 1 | Low-supply lockout, blocks writes |
| rdata_o | output | 8 | Registered read data |

## Verification
A wrong sequencer state shows up on the next read as the wrong kind of data: E8h or a protection byte where array data was expected, or a status byte in place of array contents. Each test therefore follows every command sequence with a read one strobe later. A wrong busy counter shows up as status bytes that stop too early or too late, or as a programmed value that never lands. For that reason each program and erase reads two status bytes at known points in the operation, then reads the array after a fixed wait. A fault state that does not hold, or an array that changes on a fault, shows up after F0h as a byte that differs from the bench's shadow copy.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_UNL1,
    ST_UNL2,
    ST_QUERY,
    ST_PGM_ARM,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3,
    ST_BUSY,
    ST_FAULT
  } seq_st_e;

  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  OP_QUERY  = 8'h90;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_ERASE  = 8'h80;
  localparam logic [7:0]  OP_ERS_GO = 8'h30;
  localparam logic [7:0]  OP_RESET  = 8'hF0;
  localparam logic [7:0]  DEV_ID    = 8'hE8;
  localparam logic [11:0] KEY_ADR_A = 12'h555;
  localparam logic [11:0] KEY_ADR_B = 12'hAAA;
endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              prot_i,
  input  logic [7:0]        old_i,
  input  logic              done_i,
  output seq_st_e           state_o,
  output logic              go_pgm_o,
  output logic              go_ers_o,
  output logic              fault_o,
  output logic              poll_o,
  output logic              ers_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADR_B);

  seq_st_e st_q, st_d;
  logic    at_a, at_b, is_rst, bad_pgm;
  logic    poll_q, ers_q;

  assign at_a    = (addr_i == ADR_A);
  assign at_b    = (addr_i == ADR_B);
  assign is_rst  = wr_evt_i && (data_i == OP_RESET);
  // program may only clear bits
  assign bad_pgm = prot_i || ((data_i & ~old_i) != 8'h00);

  always_comb begin
    st_d     = st_q;
    go_pgm_o = 1'b0;
    go_ers_o = 1'b0;
    fault_o  = 1'b0;
    case (st_q)
      ST_ARRAY: if (wr_evt_i && at_a && data_i == KEY_A) st_d = ST_UNL1;
      ST_UNL1: if (wr_evt_i) st_d = (at_b && data_i == KEY_B) ? ST_UNL2 : ST_ARRAY;
      ST_UNL2: begin
        if (wr_evt_i) begin
          st_d = ST_ARRAY;
          if (at_a) begin
            case (data_i)
              OP_QUERY: st_d = ST_QUERY;
              OP_PROG:  st_d = ST_PGM_ARM;
              OP_ERASE: st_d = ST_ERS1;
              default:  st_d = ST_ARRAY;
            endcase
          end
        end
      end
      ST_QUERY: if (is_rst) st_d = ST_ARRAY;
      ST_PGM_ARM: begin
        if (wr_evt_i) begin
          if (bad_pgm) begin
            st_d    = ST_FAULT;
            fault_o = 1'b1;
          end else begin
            st_d     = ST_BUSY;
            go_pgm_o = 1'b1;
          end
        end
      end
      ST_ERS1: if (wr_evt_i) st_d = (at_a && data_i == KEY_A) ? ST_ERS2 : ST_ARRAY;
      ST_ERS2: if (wr_evt_i) st_d = (at_b && data_i == KEY_B) ? ST_ERS3 : ST_ARRAY;
      ST_ERS3: begin
        if (wr_evt_i) begin
          if (data_i != OP_ERS_GO) begin
            st_d = ST_ARRAY;
          end else if (prot_i) begin
            st_d    = ST_FAULT;
            fault_o = 1'b1;
          end else begin
            st_d     = ST_BUSY;
            go_ers_o = 1'b1;
          end
        end
      end
      ST_BUSY:  if (done_i) st_d = ST_ARRAY;
      ST_FAULT: if (is_rst) st_d = ST_ARRAY;
      default:  st_d = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_ARRAY;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= 1'b0;
      ers_q  <= 1'b0;
    end else if (wr_evt_i && st_q == ST_PGM_ARM) begin
      poll_q <= ~data_i[7];
      ers_q  <= 1'b0;
    end else if (wr_evt_i && st_q == ST_ERS3 && data_i == OP_ERS_GO) begin
      poll_q <= 1'b0;
      ers_q  <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign poll_o  = poll_q;
  assign ers_o   = ers_q;
  assign err_o   = (st_q == ST_FAULT);

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY && !done_i) |=> st_q == ST_BUSY);
  p_fault_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FAULT && !(wr_evt_i && data_i == OP_RESET)) |=> st_q == ST_FAULT);
  p_abort_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_UNL1 && wr_evt_i && data_i != KEY_B) |=> st_q == ST_ARRAY);
  p_query_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUERY && wr_evt_i && data_i == OP_RESET) |=> st_q == ST_ARRAY);
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned PGM_CYC = 10,
  parameter int unsigned ERS_CYC = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_pgm_i,
  input  logic start_ers_i,
  output logic done_o
);
  localparam int unsigned MAX_CYC = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_pgm_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(PGM_CYC - 1);
    end else if (start_ers_i) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(ERS_CYC - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q < CNT_W'(MAX_CYC));
  p_done_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_pgm_i && !start_ers_i) |=> !run_q);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       rd_i,
  input  logic       poll_i,
  input  logic       err_i,
  input  logic       ers_i,
  output logic [7:0] stat_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    tgl_q <= 1'b0;
    else if (clr_i) tgl_q <= 1'b0;
    else if (rd_i)  tgl_q <= ~tgl_q;
  end

  assign stat_o = {poll_i, tgl_q, err_i, 1'b0, ers_i, 3'b000};

  p_toggle_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !clr_i) |=> tgl_q != $past(tgl_q));
  p_toggle_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !clr_i) |=> $stable(tgl_q));
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int unsigned NSECT  = 4,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned SIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIDX_W-1:0] rd_sec_i,
  input  logic [OFS_W-1:0]  rd_ofs_i,
  output logic [7:0]        rd_dat_o,
  input  logic              pgm_en_i,
  input  logic [SIDX_W-1:0] pgm_sec_i,
  input  logic [OFS_W-1:0]  pgm_ofs_i,
  input  logic [7:0]        pgm_dat_i,
  input  logic              ers_en_i,
  input  logic [SIDX_W-1:0] ers_sec_i
);
  localparam int unsigned DEPTH = 1 << OFS_W;

  logic [7:0] sec_rd [NSECT];

  for (genvar s = 0; s < NSECT; s++) begin : g_sec
    logic [7:0] cells [DEPTH];
    logic       ers_hit, pgm_hit;

    assign ers_hit = ers_en_i && (ers_sec_i == SIDX_W'(s));
    assign pgm_hit = pgm_en_i && (pgm_sec_i == SIDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) cells[k] <= 8'hFF;
      end else if (ers_hit) begin
        for (int k = 0; k < DEPTH; k++) cells[k] <= 8'hFF;
      end else if (pgm_hit) begin
        cells[pgm_ofs_i] <= cells[pgm_ofs_i] & pgm_dat_i;
      end
    end

    assign sec_rd[s] = cells[rd_ofs_i];

    p_erase_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ers_hit |=> (cells[0] == 8'hFF && cells[DEPTH-1] == 8'hFF));
  end

  assign rd_dat_o = sec_rd[rd_sec_i];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 12,
  parameter int unsigned      NSECT     = 4,
  parameter int unsigned      OFS_W     = 4,
  parameter int unsigned      PGM_CYC   = 10,
  parameter int unsigned      ERS_CYC   = 30,
  parameter logic [NSECT-1:0] PROT_MASK = 4'b0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [NSECT-1:0]  sect_i,
  input  logic              lockout_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned SIDX_W = (NSECT > 1) ? $clog2(NSECT) : 1;

  seq_st_e           state;
  logic              we_q, re_q, sect_ok, wr_evt, rd_evt, rd_stat;
  logic [SIDX_W-1:0] sidx;
  logic              prot_bit;
  logic [OFS_W-1:0]  ofs;
  logic [7:0]        arr_dat, stat_byte, rd_mux;
  logic              go_pgm, go_ers, fault, done, poll, ers, err;
  logic              op_pgm_q;
  logic [SIDX_W-1:0] tgt_sec_q;
  logic [OFS_W-1:0]  tgt_ofs_q;
  logic [7:0]        tgt_dat_q;

  always_comb begin
    sidx = '0;
    for (int i = 0; i < NSECT; i++) if (sect_i[i]) sidx = SIDX_W'(i);
  end

  assign sect_ok  = $onehot(sect_i);
  assign prot_bit = PROT_MASK[sidx];
  assign ofs      = addr_i[OFS_W-1:0];

  // strobe registers reset high: a strobe held through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_i;
      re_q <= re_i;
    end
  end

  assign wr_evt  = we_i && !we_q && !lockout_i && sect_ok;
  assign rd_evt  = re_i && !re_q && sect_ok;
  assign rd_stat = rd_evt && (state == ST_BUSY || state == ST_FAULT);

  flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_evt_i (wr_evt),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .prot_i   (prot_bit),
    .old_i    (arr_dat),
    .done_i   (done),
    .state_o  (state),
    .go_pgm_o (go_pgm),
    .go_ers_o (go_ers),
    .fault_o  (fault),
    .poll_o   (poll),
    .ers_o    (ers),
    .err_o    (err)
  );

  flash_busy_timer #(.PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_pgm_i (go_pgm),
    .start_ers_i (go_ers),
    .done_o      (done)
  );

  flash_status_gen u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (go_pgm | go_ers | fault),
    .rd_i   (rd_stat),
    .poll_i (poll),
    .err_i  (err),
    .ers_i  (ers),
    .stat_o (stat_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_pgm_q  <= 1'b0;
      tgt_sec_q <= '0;
      tgt_ofs_q <= '0;
      tgt_dat_q <= 8'h00;
    end else if (go_pgm || go_ers) begin
      op_pgm_q  <= go_pgm;
      tgt_sec_q <= sidx;
      tgt_ofs_q <= ofs;
      tgt_dat_q <= data_i;
    end
  end

  flash_cell_array #(.NSECT(NSECT), .OFS_W(OFS_W), .SIDX_W(SIDX_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_sec_i  (sidx),
    .rd_ofs_i  (ofs),
    .rd_dat_o  (arr_dat),
    .pgm_en_i  (done && op_pgm_q),
    .pgm_sec_i (tgt_sec_q),
    .pgm_ofs_i (tgt_ofs_q),
    .pgm_dat_i (tgt_dat_q),
    .ers_en_i  (done && !op_pgm_q),
    .ers_sec_i (tgt_sec_q)
  );

  always_comb begin
    case (state)
      ST_BUSY, ST_FAULT: rd_mux = stat_byte;
      ST_QUERY: begin
        case (addr_i[1:0])
          2'd0:    rd_mux = DEV_ID;
          2'd2:    rd_mux = {7'd0, prot_bit};
          default: rd_mux = 8'h00;
        endcase
      end
      default: rd_mux = arr_dat;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= 8'h00;
    else if (rd_evt) rdata_o <= rd_mux;
  end

  p_lockout_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockout_i && state == ST_ARRAY) |=> state == ST_ARRAY);
  p_query_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && state == ST_QUERY && addr_i[1:0] == 2'd0) |=> rdata_o == DEV_ID);
  p_done_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> state == ST_BUSY);
  p_rd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_evt |=> $stable(rdata_o));
  p_busy_nowrite_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_BUSY) |-> !(go_pgm || go_ers || fault));
endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam int unsigned NS = 4;
  localparam int unsigned OW = 4;
  localparam int unsigned PC = 10;
  localparam int unsigned EC = 30;
  localparam logic [3:0]  PM = 4'b0100;
  localparam int unsigned DEP = 1 << OW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic [7:0]  data;
  logic        we, re, lockout;
  logic [3:0]  sect;
  logic [7:0]  rdata;

  always #5 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W(12), .NSECT(NS), .OFS_W(OW), .PGM_CYC(PC), .ERS_CYC(EC), .PROT_MASK(PM)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .we_i(we),
    .re_i(re), .sect_i(sect), .lockout_i(lockout), .rdata_o(rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [NS*DEP];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input int s);
    @(negedge clk);
    addr = a; data = d; sect = 4'b0001 << s; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] sel, output logic [7:0] v);
    @(negedge clk);
    addr = a; sect = sel; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    v = rdata;
  endtask

  task automatic unlock(input int s);
    wr(12'h555, 8'hAA, s);
    wr(12'hAAA, 8'h55, s);
  endtask

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'(s * 53 + k * 29) ^ 8'h5A;
  endfunction

  task automatic pgm(input int s, input int k, input logic [7:0] d);
    logic [7:0] v, st0;
    int idx;
    logic bad;
    idx = s * DEP + k;
    bad = PM[s] || ((d & ~model[idx]) != 8'h00);
    unlock(s);
    wr(12'h555, 8'hA0, s);
    wr(12'(k), d, s);
    st0 = {~d[7], 1'b0, bad, 5'b00000};
    rd(12'(k), 4'b0001 << s, v);
    chk(bad ? "R11 fault status" : "R8 program status", v, st0);
    rd(12'(k), 4'b0001 << s, v);
    chk("R9 toggle flips", v, st0 | 8'h40);
    repeat (EC + 2) @(negedge clk);
    if (bad) begin
      rd(12'(k), 4'b0001 << s, v);
      chk("R11 fault held", v, st0);
      wr(12'h000, 8'hF0, s);
    end else begin
      model[idx] = model[idx] & d;
    end
    rd(12'(k), 4'b0001 << s, v);
    chk("R7 stored byte", v, model[idx]);
  endtask

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < DEP; k++) begin
        rd(12'(k), 4'b0001 << s, v);
        chk(req, v, model[s*DEP+k]);
      end
  endtask

  task automatic erase(input int s);
    logic [7:0] v, st0;
    unlock(s);
    wr(12'h555, 8'h80, s);
    unlock(s);
    wr(12'h003, 8'h30, s);
    st0 = {3'b000, PM[s], 1'b0, 1'b1, 2'b00} << 0;
    st0 = {2'b00, PM[s], 1'b0, 1'b1, 3'b000};
    rd(12'h003, 4'b0001 << s, v);
    chk(PM[s] ? "R11 erase fault status" : "R10 erase status", v, st0);
    rd(12'h003, 4'b0001 << s, v);
    chk("R9 erase toggle", v, st0 | 8'h40);
    repeat (EC + 2) @(negedge clk);
    if (PM[s]) wr(12'h000, 8'hF0, s);
    else for (int k = 0; k < DEP; k++) model[s*DEP+k] = 8'hFF;
  endtask

  initial begin : watchdog
    #1_500_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int idx;
    for (int i = 0; i < NS * DEP; i++) model[i] = 8'hFF;
    // strobe held high across reset release
    rst_n = 1'b0; we = 1'b1; re = 1'b0; lockout = 1'b0;
    addr = 12'h555; data = 8'hAA; sect = 4'b0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 read port reset", rdata, 8'h00);
    repeat (2) @(negedge clk);
    we = 1'b0;
    wr(12'hAAA, 8'h55, 0);
    wr(12'h555, 8'h90, 0);
    rd(12'h000, 4'b0001, v);
    chk("R13 no write from held strobe", v, 8'hFF);

    sweep("R1 erased after reset");

    // query mode over every sector
    unlock(0);
    wr(12'h555, 8'h90, 0);
    for (int s = 0; s < NS; s++) begin
      rd(12'h000, 4'b0001 << s, v);
      chk("R4 identifier", v, 8'hE8);
      rd(12'h002, 4'b0001 << s, v);
      chk("R5 protection byte", v, {7'd0, PM[s]});
      rd(12'h001, 4'b0001 << s, v);
      chk("R5 other query address", v, 8'h00);
    end
    wr(12'h000, 8'hF0, 1);
    rd(12'h000, 4'b0001, v);
    chk("R6 reset leaves query", v, 8'hFF);

    // aborts
    wr(12'h555, 8'hAA, 0);
    wr(12'h555, 8'h55, 0);
    wr(12'h555, 8'h90, 0);
    rd(12'h000, 4'b0001, v);
    chk("R3 wrong second address aborts", v, 8'hFF);
    unlock(0);
    wr(12'h555, 8'h77, 0);
    wr(12'h555, 8'h90, 0);
    rd(12'h000, 4'b0001, v);
    chk("R3 wrong command aborts", v, 8'hFF);
    unlock(0);
    wr(12'h554, 8'h90, 0);
    rd(12'h000, 4'b0001, v);
    chk("R3 command at wrong address aborts", v, 8'hFF);

    // program sweep on unprotected sectors
    for (int s = 0; s < NS; s++)
      if (!PM[s])
        for (int k = 0; k < DEP; k++) pgm(s, k, pat(s, k));
    sweep("R7 array after programming");

    // reads with no sector selected leave the port alone
    rd(12'h001, 4'b0001, v);
    rd(12'h002, 4'b0000, v);
    chk("R2 unselected read ignored", v, model[1]);
    // read during an unlock sequence serves array data
    wr(12'h555, 8'hAA, 0);
    rd(12'h004, 4'b0001, v);
    chk("R2 read mid-sequence", v, model[4]);
    wr(12'h000, 8'hF0, 0);

    // bit set attempt and protected sector
    pgm(0, 0, 8'hFF);
    pgm(2, 3, 8'h00);
    pgm(2, 5, 8'h80);

    // reset as the unlocked command byte
    unlock(1);
    wr(12'h555, 8'hF0, 1);
    rd(12'h000, 4'b0010, v);
    chk("R6 unlocked reset command", v, model[DEP]);

    // lockout
    lockout = 1'b1;
    unlock(0);
    wr(12'h555, 8'h90, 0);
    lockout = 1'b0;
    rd(12'h000, 4'b0001, v);
    chk("R12 lockout blocks query", v, model[0]);

    // writes during busy are ignored
    idx = 3 * DEP + 1;
    unlock(3);
    wr(12'h555, 8'hA0, 3);
    wr(12'h001, model[idx] & 8'h0F, 3);
    wr(12'h555, 8'hAA, 3);
    wr(12'h000, 8'h00, 3);
    model[idx] = model[idx] & 8'h0F;
    repeat (PC + 2) @(negedge clk);
    wr(12'hAAA, 8'h55, 3);
    wr(12'h555, 8'h90, 3);
    rd(12'h000, 4'b1000, v);
    chk("R13 busy write ignored", v, model[3*DEP]);
    rd(12'h001, 4'b1000, v);
    chk("R13 busy program landed", v, model[idx]);

    // erases
    erase(1);
    erase(2);
    sweep("R10 array after erase");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule